// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Bit-Time Realignment

This block receives asynchronous serial characters from a single line. It uses a sample tick enable that fires sixteen times per bit time. The line passes through a two-flop synchronizer and is then examined only on tick cycles. A character begins with a falling edge that follows a quiet (high) line. Data arrives least significant bit first and is 8 or 9 bits long. Every bit, including start and stop, is sampled on its eighth, ninth and tenth tick, and its value is the majority of those three samples.

When the samples of any bit disagree, the noise flag is raised. A stop bit that votes 0 raises the framing flag. An all-zero character whose stop bit also votes 0 is reported as a break. The receiver then stays parked until the line goes high again. Inside a character, each falling edge pulls the tick counter back into line with the sender. An edge seen early in a bit restarts that bit. An edge seen after the bit's samples have been taken starts the next bit. This correction keeps senders several percent off nominal speed inside the sampling window.

Results are held in a data register with a full flag and four status flags. A single-cycle clear input drops all of them. A character that completes while the full flag is still up is discarded, and only the overrun flag records it.

Top module: `os_uart_rx`

## Requirements
- R1: After reset, rx_full, err_frame, err_noise, err_break and err_overrun are 0 and rx_data is all zeros.
- R2: A falling edge starts a character only if the line was sampled high on at least the 3 preceding ticks. A start bit whose RT8–RT10 samples vote 1 is dropped and nothing is received.
- R3: Tick RT1 is the first tick that sees the synchronized line low. In 8-bit mode (nine_bit = 0) the character completes on tick 154, and rx_full rises at that tick's clock edge. Bit i lands in rx_data[i], with bit 0 first on the line, and rx_data[8] reads 0.
- R4: In 9-bit mode (nine_bit = 1) the character completes on tick 170, and all of rx_data[8:0] is loaded.
- R5: Each bit takes the majority of its RT8, RT9 and RT10 samples. One odd sample in a data bit leaves that bit's value unchanged but sets err_noise.
- R6: Stop-bit samples that disagree but vote 1 set err_noise and leave err_frame at 0.
- R7: A stop bit that votes 0 sets err_frame. err_frame is set in the same cycle that rx_full rises, never before.
- R8: If all data bits and the stop bit vote 0, err_break and err_frame are set. No new start is then accepted until the line has been high for 3 ticks after it returns high.
- R9: A sender running 4% slow or 4% fast is received without any error flag, in both lengths and with any data. This relies on realignment at falling edges inside the character.
- R10: A sender 10% slow sending 0x01 in 8-bit mode produces err_frame.
- R11: rx_full and every status flag stay set until clr is pulsed. A clr pulse drops them all.
- R12: A character that completes while rx_full is set sets err_overrun and leaves rx_data unchanged.
- R13: When clr coincides with the completion cycle, the new character is taken: rx_full = 1, rx_data holds the new word, and err_overrun = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample enable, 16 pulses per bit time |
| rxd | input | 1 | Serial line, idle high |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| clr | input | 1 | One-cycle pulse clearing full and all flags |
| rx_data | output | 9 | Last accepted character |
| rx_full | output | 1 | A character is waiting |
| err_frame | output | 1 | Stop bit voted 0 |
| err_noise | output | 1 | Some bit had disagreeing samples |
| err_break | output | 1 | All-zero character with zero stop |
| err_overrun | output | 1 | A character was lost because rx_full was set |

## Verification
Two things can land on the same clock edge. One is the completion of a character: the stop decision on RT10 of the stop bit. The other is a clr pulse from the consumer. The bench owns the tick input, so it knows the exact tick index of the stop decision and can drive clr together with that tick while an earlier character is still held. The outcome is judged at the ports. The new word must be present with rx_full high, and no overrun may be recorded. A second coincidence is also checked: the framing flag must not show one tick early and must appear together with rx_full.

// File: rtl/os_rx_pkg.sv
package os_rx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_STOP,
    S_BRKW
  } rx_state_e;

  // majority of three samples
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // any disagreement among three samples
  function automatic logic split3(input logic a, input logic b, input logic c);
    return (a ^ b) | (b ^ c);
  endfunction

  // classify an in-character falling edge by tick index within the bit:
  // bit 0 = late (restart current bit), bit 1 = early (begin next bit)
  function automatic logic [1:0] rs_zone(input int unsigned idx,
                                         input int unsigned first_smp,
                                         input int unsigned last_smp);
    logic [1:0] z;
    z[0] = (idx >= 1) && (idx < first_smp);
    z[1] = (idx > last_smp);
    return z;
  endfunction

endpackage

// File: rtl/os_rx_line.sv
module os_rx_line #(
  parameter int MIN_IDLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxd,
  output logic line,
  output logic fall,
  output logic quiet_ok
);
  localparam int CW = $clog2(MIN_IDLE + 1);

  logic [1:0]    sync_q;
  logic          prev_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], rxd};
      if (tick) begin
        prev_q <= line;
        if (!line)                      run_q <= '0;
        else if (run_q != CW'(MIN_IDLE)) run_q <= run_q + 1'b1;
      end
    end
  end

  assign line     = sync_q[1];
  assign fall     = tick & prev_q & ~line;
  assign quiet_ok = (run_q == CW'(MIN_IDLE));

endmodule

// File: rtl/os_rx_engine.sv
module os_rx_engine
  import os_rx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int SMP_FIRST = 8,
  parameter int DW        = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line,
  input  logic          fall,
  input  logic          quiet_ok,
  input  logic          nine_bit,
  output logic          done_o,
  output logic [DW-1:0] word_o,
  output logic          fe_o,
  output logic          nf_o,
  output logic          brk_o
);
  localparam int RTW = $clog2(OSR);
  localparam int BW  = $clog2(DW + 1);
  localparam logic [RTW-1:0] I_S0  = RTW'(SMP_FIRST - 1);
  localparam logic [RTW-1:0] I_S1  = RTW'(SMP_FIRST);
  localparam logic [RTW-1:0] I_S2  = RTW'(SMP_FIRST + 1);
  localparam logic [RTW-1:0] I_END = RTW'(OSR - 1);
  localparam logic [RTW-1:0] I_ONE = RTW'(1);

  rx_state_e     state_q;
  logic [RTW-1:0] rt_q;
  logic [BW-1:0]  bidx_q;
  logic [1:0]     s_q;
  logic [DW-1:0]  word_q;
  logic           nf_q;

  logic          vote, odd, decide, in_frame;
  logic [1:0]    zone;
  logic          resync_late, resync_early, bit_end, false_start;
  logic [BW-1:0] last_idx;

  assign vote     = vote3(s_q[0], s_q[1], line);
  assign odd      = split3(s_q[0], s_q[1], line);
  assign in_frame = (state_q == S_START) || (state_q == S_DATA) || (state_q == S_STOP);
  assign decide   = tick && in_frame && (rt_q == I_S2);
  assign zone     = rs_zone(32'(rt_q), 32'(I_S0), 32'(I_S2));
  assign resync_late  = fall && (state_q == S_DATA) && zone[0];
  assign resync_early = fall && (state_q == S_DATA) && zone[1];
  assign bit_end  = tick && ((state_q == S_START) || (state_q == S_DATA)) &&
                    ((rt_q == I_END) || resync_early);
  assign false_start = decide && (state_q == S_START) && vote;
  assign last_idx = nine_bit ? BW'(DW - 1) : BW'(DW - 2);

  assign done_o = decide && (state_q == S_STOP);
  assign word_o = word_q;
  assign fe_o   = ~vote;
  assign nf_o   = nf_q | odd;
  assign brk_o  = ~vote && (word_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      rt_q    <= '0;
      bidx_q  <= '0;
      s_q     <= '0;
      word_q  <= '0;
      nf_q    <= 1'b0;
    end else if (tick) begin
      case (state_q)
        S_IDLE: begin
          if (fall && quiet_ok) begin
            state_q <= S_START;
            rt_q    <= I_ONE;
            bidx_q  <= '0;
            word_q  <= '0;
            nf_q    <= 1'b0;
          end
        end
        S_BRKW: begin
          if (line) state_q <= S_IDLE;
        end
        default: begin
          if (resync_late || resync_early) rt_q <= I_ONE;
          else if (rt_q == I_END)          rt_q <= '0;
          else                             rt_q <= rt_q + 1'b1;
          if (rt_q == I_S0) s_q[0] <= line;
          if (rt_q == I_S1) s_q[1] <= line;
          if (decide) begin
            case (state_q)
              S_START: if (vote) state_q <= S_IDLE; else nf_q <= odd;
              S_DATA: begin
                word_q[bidx_q] <= vote;
                nf_q           <= nf_q | odd;
              end
              default: state_q <= brk_o ? S_BRKW : S_IDLE;
            endcase
          end
          if (bit_end && !false_start) begin
            if (state_q == S_START) begin
              state_q <= S_DATA;
              bidx_q  <= '0;
            end else if (bidx_q == last_idx) begin
              state_q <= S_STOP;
            end else begin
              bidx_q <= bidx_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R2
  quiet_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && fall && !quiet_ok) |=> (state_q == S_IDLE));

  // R2
  false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && state_q == S_START && rt_q == I_S2 && s_q == 2'b11 && line) |=> (state_q == S_IDLE));

  // R8
  brk_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_BRKW) |-> !quiet_ok);

endmodule

// File: rtl/os_rx_status.sv
module os_rx_status #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_i,
  input  logic [DW-1:0] word_i,
  input  logic          fe_i,
  input  logic          nf_i,
  input  logic          brk_i,
  input  logic          clr_i,
  output logic [DW-1:0] rx_data,
  output logic          rx_full,
  output logic          err_frame,
  output logic          err_noise,
  output logic          err_break,
  output logic          err_overrun
);
  logic full_eff;
  assign full_eff = rx_full & ~clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_full     <= 1'b0;
      err_frame   <= 1'b0;
      err_noise   <= 1'b0;
      err_break   <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      if (clr_i) begin
        rx_full     <= 1'b0;
        err_frame   <= 1'b0;
        err_noise   <= 1'b0;
        err_break   <= 1'b0;
        err_overrun <= 1'b0;
      end
      if (done_i) begin
        if (full_eff) begin
          err_overrun <= 1'b1;
        end else begin
          rx_data   <= word_i;
          rx_full   <= 1'b1;
          err_frame <= fe_i;
          err_noise <= nf_i;
          err_break <= brk_i;
        end
      end
    end
  end

  // R7
  fe_with_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_frame) |-> (rx_full && $past(done_i)));

  // R12
  ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !clr_i && done_i) |=> ($stable(rx_data) && err_overrun));

  // R11
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !clr_i) |=> rx_full);

endmodule

// File: rtl/os_uart_rx.sv
module os_uart_rx #(
  parameter int OSR       = 16,
  parameter int SMP_FIRST = 8,
  parameter int MIN_IDLE  = 3,
  parameter int DW        = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic          nine_bit,
  input  logic          clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_full,
  output logic          err_frame,
  output logic          err_noise,
  output logic          err_break,
  output logic          err_overrun
);
  logic          line, fall, quiet_ok;
  logic          done, fe, nf, brk;
  logic [DW-1:0] word;

  os_rx_line #(.MIN_IDLE(MIN_IDLE)) u_line (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .line(line), .fall(fall), .quiet_ok(quiet_ok)
  );

  os_rx_engine #(.OSR(OSR), .SMP_FIRST(SMP_FIRST), .DW(DW)) u_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line(line), .fall(fall),
    .quiet_ok(quiet_ok), .nine_bit(nine_bit), .done_o(done), .word_o(word),
    .fe_o(fe), .nf_o(nf), .brk_o(brk)
  );

  os_rx_status #(.DW(DW)) u_status (
    .clk(clk), .rst_n(rst_n), .done_i(done), .word_i(word), .fe_i(fe),
    .nf_i(nf), .brk_i(brk), .clr_i(clr), .rx_data(rx_data), .rx_full(rx_full),
    .err_frame(err_frame), .err_noise(err_noise), .err_break(err_break),
    .err_overrun(err_overrun)
  );

  // R3
  tick_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> tick);

endmodule

// File: tb/tb_os_uart_rx.sv
module tb_os_uart_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic       nine_bit = 1'b0;
  logic       clr = 1'b0;
  logic [8:0] rx_data;
  logic       rx_full, err_frame, err_noise, err_break, err_overrun;

  int pass_cnt = 0;
  int fail_cnt = 0;

  os_uart_rx dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .nine_bit(nine_bit),
    .clr(clr), .rx_data(rx_data), .rx_full(rx_full), .err_frame(err_frame),
    .err_noise(err_noise), .err_break(err_break), .err_overrun(err_overrun)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    if (ok) pass_cnt++;
    else begin
      fail_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // line level of a sender whose bit lasts 16*(100+skew)/100 receiver ticks;
  // k = 0 is the first low tick
  function automatic logic tx_level(input logic [8:0] d, input int nb, input real skew, input int k);
    int b;
    b = $rtoi(k * 100.0 / (16.0 * (100.0 + skew)));
    if (b == 0) return 1'b0;
    if (b <= nb) return d[b-1];
    return 1'b1;
  endfunction

  function automatic int frame_len(input int nb, input real skew);
    return $rtoi((nb + 2) * 16.0 * (100.0 + skew) / 100.0) + 4;
  endfunction

  function automatic int exp_word(input logic [8:0] d, input bit nine);
    return nine ? int'(d) : int'(d & 9'h0FF);
  endfunction

  task automatic tick_once(input logic lvl, input logic c);
    @(negedge clk) rxd = lvl;
    @(negedge clk);
    @(negedge clk);
    tick = 1'b1;
    clr  = c;
    @(negedge clk);
    tick = 1'b0;
    clr  = 1'b0;
  endtask

  task automatic frame(input logic [8:0] d, input bit nine, input real skew,
                       input int k0, input int k1, input int clr_k,
                       input int g0, input int g1, input int pre);
    int nb;
    logic lvl;
    nb = nine ? 9 : 8;
    nine_bit = nine;
    repeat (pre) tick_once(1'b1, 1'b0);
    for (int k = k0; k < k1; k++) begin
      lvl = tx_level(d, nb, skew, k);
      if (k >= g0 && k <= g1) lvl = ~lvl;
      tick_once(lvl, k == clr_k);
    end
  endtask

  task automatic full_frame(input logic [8:0] d, input bit nine, input real skew);
    frame(d, nine, skew, 0, frame_len(nine ? 9 : 8, skew), -1, -1, -2, 4);
  endtask

  task automatic clr_pulse();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic do_break();
    clr_pulse();
    frame(9'h000, 1'b0, 0.0, 0, 200, -1, 144, 199, 4);
  endtask

  initial begin
    #(4 * 190000);
    fail_cnt++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    $finish;
  end

  initial begin
    logic [8:0] d;
    bit nine;
    real sk;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk({rx_full, err_frame, err_noise, err_break, err_overrun} == 5'b0, "R1 flags", {rx_full, err_frame, err_noise, err_break, err_overrun}, 0);
    chk(rx_data == 9'h0, "R1 data", rx_data, 0);

    // R3 8-bit completion on tick 154
    frame(9'h0A5, 1'b0, 0.0, 0, 153, -1, -1, -2, 4);
    chk(rx_full == 1'b0, "R3 not before 154", rx_full, 0);
    frame(9'h0A5, 1'b0, 0.0, 153, 154, -1, -1, -2, 0);
    chk(rx_full == 1'b1, "R3 full at 154", rx_full, 1);
    chk(rx_data == 9'h0A5, "R3 data", rx_data, 9'h0A5);
    frame(9'h0A5, 1'b0, 0.0, 154, 170, -1, -1, -2, 0);

    // R4 9-bit completion on tick 170
    clr_pulse();
    frame(9'h1C3, 1'b1, 0.0, 0, 169, -1, -1, -2, 4);
    chk(rx_full == 1'b0, "R4 not before 170", rx_full, 0);
    frame(9'h1C3, 1'b1, 0.0, 169, 170, -1, -1, -2, 0);
    chk(rx_full == 1'b1, "R4 full at 170", rx_full, 1);
    chk(rx_data == 9'h1C3, "R4 data", rx_data, 9'h1C3);
    frame(9'h1C3, 1'b1, 0.0, 170, 190, -1, -1, -2, 0);

    // R2 false start: 5 low ticks then idle
    clr_pulse();
    repeat (4) tick_once(1'b1, 1'b0);
    repeat (5) tick_once(1'b0, 1'b0);
    repeat (200) tick_once(1'b1, 1'b0);
    chk(rx_full == 1'b0, "R2 false start dropped", rx_full, 0);

    // R5 one odd sample in data bit 0 (RT9)
    clr_pulse();
    frame(9'h055, 1'b0, 0.0, 0, 180, -1, 24, 24, 4);
    chk(rx_data == 9'h055, "R5 majority data", rx_data, 9'h055);
    chk(err_noise == 1'b1 && err_frame == 1'b0, "R5 noise", {err_noise, err_frame}, 2'b10);

    // R6 odd sample in stop bit (RT9)
    clr_pulse();
    frame(9'h03C, 1'b0, 0.0, 0, 180, -1, 152, 152, 4);
    chk(err_noise == 1'b1 && err_frame == 1'b0 && rx_full, "R6 stop noise", {rx_full, err_noise, err_frame}, 3'b110);

    // R7 stop votes 0, flag appears with full only
    clr_pulse();
    frame(9'h03C, 1'b0, 0.0, 0, 153, -1, 150, 153, 4);
    chk(err_frame == 1'b0 && rx_full == 1'b0, "R7 nothing early", {rx_full, err_frame}, 0);
    frame(9'h03C, 1'b0, 0.0, 153, 180, -1, 150, 153, 0);
    chk(err_frame && rx_full && !err_break, "R7 frame with full", {rx_full, err_frame, err_break}, 3'b110);

    // R8 break
    do_break();
    chk(err_break && err_frame && rx_full && rx_data == 9'h0, "R8 break flags", {err_break, err_frame, rx_full}, 3'b111);
    // R2 only 2 high ticks before a start: ignored
    clr_pulse();
    repeat (2) tick_once(1'b1, 1'b0);
    frame(9'h0FF, 1'b0, 0.0, 0, 180, -1, -1, -2, 0);
    chk(rx_full == 1'b0, "R2 short quiet ignored", rx_full, 0);
    // R2 exactly 3 high ticks: accepted
    do_break();
    clr_pulse();
    repeat (3) tick_once(1'b1, 1'b0);
    frame(9'h03C, 1'b0, 0.0, 0, 180, -1, -1, -2, 0);
    chk(rx_full && rx_data == 9'h03C && !err_break, "R2 three quiet accepted", rx_data, 9'h03C);

    // R11 hold and clear
    repeat (50) tick_once(1'b1, 1'b0);
    chk(rx_full == 1'b1, "R11 held", rx_full, 1);
    clr_pulse();
    chk({rx_full, err_frame, err_noise, err_break, err_overrun} == 5'b0, "R11 cleared", {rx_full, err_frame, err_noise, err_break, err_overrun}, 0);

    // R12 overrun
    full_frame(9'h011, 1'b0, 0.0);
    full_frame(9'h099, 1'b0, 0.0);
    chk(err_overrun && rx_data == 9'h011, "R12 overrun keeps data", rx_data, 9'h011);

    // R13 clear coincides with completion
    clr_pulse();
    full_frame(9'h022, 1'b0, 0.0);
    frame(9'h066, 1'b0, 0.0, 0, 180, 153, -1, -2, 4);
    chk(rx_full && rx_data == 9'h066 && !err_overrun, "R13 completion wins", rx_data, 9'h066);

    // R10 10% slow, 0x01
    clr_pulse();
    full_frame(9'h001, 1'b0, 10.0);
    chk(err_frame == 1'b1, "R10 skew framing", err_frame, 1);

    // R9 directed skew corners
    clr_pulse();
    full_frame(9'h000, 1'b0, 4.0);
    chk(rx_full && rx_data == 9'h000 && {err_frame, err_noise, err_break} == 3'b0, "R9 slow zeros", rx_data, 0);
    clr_pulse();
    full_frame(9'h1FF, 1'b1, -4.0);
    chk(rx_full && rx_data == 9'h1FF && {err_frame, err_noise, err_break} == 3'b0, "R9 fast ones", rx_data, 9'h1FF);

    // R9 random data, length and skew within 4%
    for (int i = 0; i < 16; i++) begin
      d    = 9'($urandom);
      nine = 1'($urandom);
      sk   = real'(int'($urandom % 9) - 4);
      clr_pulse();
      full_frame(d, nine, sk);
      chk(rx_full == 1'b1, "R9 random full", rx_full, 1);
      chk(int'(rx_data) == exp_word(d, nine), "R9 random data", rx_data, exp_word(d, nine));
      chk({err_frame, err_noise, err_break, err_overrun} == 4'b0, "R9 random clean", {err_frame, err_noise, err_break, err_overrun}, 0);
    end

    $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    $finish;
  end
endmodule